// File: doc/BRIEF.md
# Paged Flash Segment Select Decoder

This decoder sits between an 8031-class microcontroller and its memories. Program space is 64 KB, but the flash behind it holds 128 KB as eight 16 KB segments, each with its own chip select. The lower 32 KB of code space always reaches the same two segments. The upper 32 KB is a window that shows one of three segment pairs, chosen by a small page register that firmware writes in data space. Because the lower half never moves, code placed there can call routines on any page and get back safely.

The flash die itself holds 512 KB. The decoder drives the die's upper address lines so that the selected segment lands at a fixed place inside the die. A boot flag, set by reset and cleared by firmware, sends lower-half fetches to a boot ROM while start-up and in-system programming code runs. SRAM and an I/O window are decoded from data read and write cycles. They do not depend on the page, so every page can reach them.

Top module: `paged_flash_decoder`

## Requirements
- R1: After reset the page register holds 0 and the boot flag is set. With no strobe active, every select output and every die address line is 0.
- R2: A code fetch in 0x0000–0x7FFF with the boot flag clear asserts seg_cs[0] when address bit 14 is 0 and seg_cs[1] when it is 1, whatever the page.
- R3: A code fetch in 0x8000–0xFFFF asserts seg_cs[2 + 2·page + bit 14] for page 0, 1 or 2. With page 3 it asserts no select at all.
- R4: flash_hi_addr is {A18,A17,A16,A15,A14}. A16..A14 carry the 3-bit number of the asserted segment and A18:A17 stay 0. All five lines are 0 when no segment select is asserted.
- R5: A data write to 0xF800 loads cpu_wdata[1:0] into the page register, and the new page takes effect on the next cycle. A write to any other address leaves the page unchanged.
- R6: While the boot flag is set, a code fetch in 0x0000–0x7FFF asserts boot_cs instead of a segment select, with die address 0. Upper-half fetches are not affected. Any data write to 0xF801 clears the flag from the next cycle on.
- R7: A data read or write asserts sram_cs in 0x0000–0x7FFF and io_cs in 0xF000–0xFFFF, which includes both control addresses. It asserts nothing in 0x8000–0xEFFF. The result is the same for every page.
- R8: Segment and boot selects need fetch to be the only strobe active. SRAM and I/O selects need exactly one of rd or wr with fetch low. When strobes conflict, nothing is selected. At most one select is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the page register and the boot flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address, code or data space |
| cpu_fetch | input | 1 | Program fetch strobe, active high |
| cpu_rd | input | 1 | Data read strobe, active high |
| cpu_wr | input | 1 | Data write strobe, active high |
| cpu_wdata | input | 8 | Write data, used by the control addresses |
| seg_cs | output | 8 | One chip select per 16 KB flash segment |
| flash_hi_addr | output | 5 | Flash die address lines A18..A14 |
| boot_cs | output | 1 | Boot ROM select |
| sram_cs | output | 1 | SRAM select |
| io_cs | output | 1 | I/O window select |

## Verification
Fetches are made at both values of address bit 14 under each of the four pages. This tells apart a wrong pair choice, a wrong choice inside a pair, and page 3 leaking a select. Lower-half fetches are repeated after the page changes, and with the boot flag both set and cleared. This shows that the common half ignores the page and that the boot ROM takes over only that half. Data accesses at the edges of the SRAM, the gap and the I/O window, combined with writes to neighbouring control addresses, separate the address compare, the field position used for the page and page independence. Fetches combined with rd or wr check that conflicting strobes select nothing.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_FETCH = 2'd1,
      ACC_DATA  = 2'd2
   } acc_kind_e;

   // Only a single active strobe forms a valid cycle; anything else selects nothing.
   function automatic acc_kind_e classify(input logic fetch, input logic rd, input logic wr);
      if (fetch && !rd && !wr)       return ACC_FETCH;
      else if (!fetch && (rd ^ wr))  return ACC_DATA;
      else                           return ACC_NONE;
   endfunction

endpackage

// File: rtl/pfd_ctrl_regs.sv
module pfd_ctrl_regs #(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int PAGE_W        = 2,
   parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 16'hF800,
   parameter logic [ADDR_W-1:0] BOOT_CLR_ADDR = 16'hF801
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PAGE_W-1:0] page_q,
   output logic              boot_q
);

   if (PAGE_W > DATA_W) begin : g_bad_page_w
      $error("PAGE_W must fit in the write data");
   end

   logic page_we;
   logic boot_clr;

   assign page_we  = wr_valid && (addr == PAGE_REG_ADDR);
   assign boot_clr = wr_valid && (addr == BOOT_CLR_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         boot_q <= 1'b1;
      end else begin
         if (page_we)  page_q <= wdata[PAGE_W-1:0];
         if (boot_clr) boot_q <= 1'b0;
      end
   end

endmodule

// File: rtl/pfd_code_map.sv
module pfd_code_map #(
   parameter int SEG_COUNT = 8,
   parameter int PAGE_W    = 2,
   parameter int NUM_PAGES = 3,
   localparam int SEG_IDX_W = $clog2(SEG_COUNT)
) (
   input  logic                 fetch_valid,
   input  logic                 upper_half,
   input  logic                 pair_bit,
   input  logic [PAGE_W-1:0]    page,
   input  logic                 boot_mode,
   output logic [SEG_COUNT-1:0] seg_cs,
   output logic [SEG_IDX_W-1:0] seg_idx,
   output logic                 boot_cs
);

   if (SEG_COUNT != 2 + 2 * NUM_PAGES) begin : g_bad_seg_count
      $error("SEG_COUNT must equal two common segments plus two per page");
   end
   if (NUM_PAGES > (1 << PAGE_W)) begin : g_bad_pages
      $error("NUM_PAGES does not fit in PAGE_W bits");
   end

   logic                 map_hit;
   logic                 boot_take;
   logic [SEG_IDX_W-1:0] idx_calc;

   always_comb begin
      map_hit  = 1'b0;
      idx_calc = '0;
      if (!upper_half) begin
         map_hit  = 1'b1;
         idx_calc = SEG_IDX_W'(pair_bit);
      end else if (int'(page) < NUM_PAGES) begin
         map_hit  = 1'b1;
         idx_calc = SEG_IDX_W'(2 + 2 * int'(page) + int'(pair_bit));
      end
   end

   assign boot_take = boot_mode && !upper_half;
   assign boot_cs   = fetch_valid && boot_take;
   assign seg_idx   = idx_calc;

   for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
      assign seg_cs[g] = fetch_valid && map_hit && !boot_take &&
                         (idx_calc == SEG_IDX_W'(g));
   end

endmodule

// File: rtl/pfd_data_map.sv
module pfd_data_map #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] SRAM_LAST = 16'h7FFF,
   parameter logic [ADDR_W-1:0] IO_FIRST  = 16'hF000
) (
   input  logic              data_valid,
   input  logic [ADDR_W-1:0] addr,
   output logic              sram_cs,
   output logic              io_cs
);

   if (IO_FIRST <= SRAM_LAST) begin : g_bad_window
      $error("I/O window overlaps the SRAM range");
   end

   assign sram_cs = data_valid && (addr <= SRAM_LAST);
   assign io_cs   = data_valid && (addr >= IO_FIRST);

endmodule

// File: rtl/paged_flash_decoder.sv
module paged_flash_decoder #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int SEG_ADDR_W = 14,
   parameter int SEG_COUNT  = 8,
   parameter int NUM_PAGES  = 3,
   parameter int PAGE_W     = 2,
   parameter int DIE_ADDR_W = 19,
   parameter logic [ADDR_W-1:0] PAGE_REG_ADDR = 16'hF800,
   parameter logic [ADDR_W-1:0] BOOT_CLR_ADDR = 16'hF801,
   parameter logic [ADDR_W-1:0] SRAM_LAST     = 16'h7FFF,
   parameter logic [ADDR_W-1:0] IO_FIRST      = 16'hF000,
   localparam int SEG_IDX_W = $clog2(SEG_COUNT),
   localparam int HI_W      = DIE_ADDR_W - SEG_ADDR_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cpu_addr,
   input  logic                 cpu_fetch,
   input  logic                 cpu_rd,
   input  logic                 cpu_wr,
   input  logic [DATA_W-1:0]    cpu_wdata,
   output logic [SEG_COUNT-1:0] seg_cs,
   output logic [HI_W-1:0]      flash_hi_addr,
   output logic                 boot_cs,
   output logic                 sram_cs,
   output logic                 io_cs
);
   import pfd_pkg::*;

   if (ADDR_W != SEG_ADDR_W + 2) begin : g_bad_addr_w
      $error("Code space must be exactly two halves of two segments");
   end
   if (HI_W < SEG_IDX_W) begin : g_bad_die
      $error("Flash die too small for the segment count");
   end

   acc_kind_e             kind;
   logic                  fetch_valid;
   logic                  data_valid;
   logic [PAGE_W-1:0]     page_q;
   logic                  boot_q;
   logic [SEG_IDX_W-1:0]  seg_idx;

   assign kind        = classify(cpu_fetch, cpu_rd, cpu_wr);
   assign fetch_valid = (kind == ACC_FETCH);
   assign data_valid  = (kind == ACC_DATA);

   pfd_ctrl_regs #(
      .ADDR_W        (ADDR_W),
      .DATA_W        (DATA_W),
      .PAGE_W        (PAGE_W),
      .PAGE_REG_ADDR (PAGE_REG_ADDR),
      .BOOT_CLR_ADDR (BOOT_CLR_ADDR)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (data_valid && cpu_wr),
      .addr     (cpu_addr),
      .wdata    (cpu_wdata),
      .page_q   (page_q),
      .boot_q   (boot_q)
   );

   pfd_code_map #(
      .SEG_COUNT (SEG_COUNT),
      .PAGE_W    (PAGE_W),
      .NUM_PAGES (NUM_PAGES)
   ) u_code (
      .fetch_valid (fetch_valid),
      .upper_half  (cpu_addr[ADDR_W-1]),
      .pair_bit    (cpu_addr[SEG_ADDR_W]),
      .page        (page_q),
      .boot_mode   (boot_q),
      .seg_cs      (seg_cs),
      .seg_idx     (seg_idx),
      .boot_cs     (boot_cs)
   );

   pfd_data_map #(
      .ADDR_W    (ADDR_W),
      .SRAM_LAST (SRAM_LAST),
      .IO_FIRST  (IO_FIRST)
   ) u_data (
      .data_valid (data_valid),
      .addr       (cpu_addr),
      .sram_cs    (sram_cs),
      .io_cs      (io_cs)
   );

   // Segment number goes on the lowest die lines above the segment offset.
   if (HI_W > SEG_IDX_W) begin : g_die_pad
      assign flash_hi_addr = (|seg_cs) ? {{(HI_W-SEG_IDX_W){1'b0}}, seg_idx} : '0;
   end else begin : g_die_exact
      assign flash_hi_addr = (|seg_cs) ? seg_idx : '0;
   end

endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SEG_COUNT = 8,
   parameter int HI_W      = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [ADDR_W-1:0]    cpu_addr,
   input logic                 cpu_fetch,
   input logic                 cpu_rd,
   input logic                 cpu_wr,
   input logic [DATA_W-1:0]    cpu_wdata,
   input logic [SEG_COUNT-1:0] seg_cs,
   input logic [HI_W-1:0]      flash_hi_addr,
   input logic                 boot_cs,
   input logic                 sram_cs,
   input logic                 io_cs
);

   logic fetch_only;
   logic wr_only;
   assign fetch_only = cpu_fetch && !cpu_rd && !cpu_wr;
   assign wr_only    = cpu_wr && !cpu_rd && !cpu_fetch;

   assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({seg_cs, boot_cs, sram_cs, io_cs}));

   assert_flash_needs_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|seg_cs) || boot_cs) |-> fetch_only);

   assert_data_needs_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_cs || io_cs) |-> (!cpu_fetch && (cpu_rd ^ cpu_wr)));

   assert_die_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flash_hi_addr[HI_W-1:3] == '0);

   assert_die_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_cs == '0) |-> (flash_hi_addr == '0));

   assert_common_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_only && !cpu_addr[15]) |->
         (boot_cs || seg_cs == (cpu_addr[14] ? SEG_COUNT'(2) : SEG_COUNT'(1))));

   assert_boot_lower_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      boot_cs |-> !cpu_addr[15]);

   assert_boot_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_only && cpu_addr == 16'hF801) |=> !boot_cs);

   assert_page_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_only && cpu_addr == 16'hF800) |=>
         (!(fetch_only && cpu_addr[15]) ||
          ($past(cpu_wdata[1:0]) == 2'd3 ? seg_cs == '0 :
           seg_cs == (SEG_COUNT'(1) << (2 + 2 * $past(cpu_wdata[1:0]) + cpu_addr[14])))));

endmodule

bind paged_flash_decoder pfd_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .SEG_COUNT (SEG_COUNT),
   .HI_W      (HI_W)
) u_pfd_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_addr      (cpu_addr),
   .cpu_fetch     (cpu_fetch),
   .cpu_rd        (cpu_rd),
   .cpu_wr        (cpu_wr),
   .cpu_wdata     (cpu_wdata),
   .seg_cs        (seg_cs),
   .flash_hi_addr (flash_hi_addr),
   .boot_cs       (boot_cs),
   .sram_cs       (sram_cs),
   .io_cs         (io_cs)
);

// File: tb/paged_flash_decoder_test.sv
module paged_flash_decoder_test;

   localparam time HALF = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_fetch = 1'b0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  cpu_wdata = '0;
   logic [7:0]  seg_cs;
   logic [4:0]  flash_hi_addr;
   logic        boot_cs;
   logic        sram_cs;
   logic        io_cs;

   paged_flash_decoder uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_addr      (cpu_addr),
      .cpu_fetch     (cpu_fetch),
      .cpu_rd        (cpu_rd),
      .cpu_wr        (cpu_wr),
      .cpu_wdata     (cpu_wdata),
      .seg_cs        (seg_cs),
      .flash_hi_addr (flash_hi_addr),
      .boot_cs       (boot_cs),
      .sram_cs       (sram_cs),
      .io_cs         (io_cs)
   );

   always #HALF clk = ~clk;

   typedef struct {
      string       tag;
      logic [15:0] exp;
   } item_t;

   item_t       sb_q[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   logic [1:0]  m_page = 2'd0;
   logic        m_boot = 1'b1;
   bit          done = 1'b0;

   // Expected outputs packed as {seg_cs, flash_hi_addr, boot_cs, sram_cs, io_cs}.
   function automatic logic [15:0] model(input logic f, input logic r, input logic w,
                                         input logic [15:0] a);
      logic [7:0] seg = '0;
      logic [4:0] die = '0;
      logic       bt = 1'b0, sr = 1'b0, io = 1'b0;
      int         n;
      if (f && !r && !w) begin
         if (!a[15] && m_boot) bt = 1'b1;
         else begin
            n = -1;
            if (!a[15]) n = a[14] ? 1 : 0;
            else if (m_page != 2'd3) n = 2 + 2 * m_page + (a[14] ? 1 : 0);
            if (n >= 0) begin
               seg[n] = 1'b1;
               die    = 5'(n);
            end
         end
      end else if (!f && (r ^ w)) begin
         if (a <= 16'h7FFF) sr = 1'b1;
         else if (a >= 16'hF000) io = 1'b1;
      end
      return {seg, die, bt, sr, io};
   endfunction

   task automatic step(input logic f, input logic r, input logic w,
                       input logic [15:0] a, input logic [7:0] d, input string tag);
      item_t it;
      @(negedge clk);
      cpu_fetch = f; cpu_rd = r; cpu_wr = w; cpu_addr = a; cpu_wdata = d;
      it.tag = tag;
      it.exp = model(f, r, w, a);
      sb_q.push_back(it);
      @(posedge clk);
      if (w && !r && !f && a == 16'hF800) m_page = d[1:0];
      if (w && !r && !f && a == 16'hF801) m_boot = 1'b0;
   endtask

   // Monitor: compares a quarter period after the driver changes the inputs.
   always @(negedge clk) begin
      #(HALF / 2);
      if (sb_q.size() > 0) begin
         item_t it;
         logic [15:0] act;
         it  = sb_q.pop_front();
         act = {seg_cs, flash_hi_addr, boot_cs, sram_cs, io_cs};
         n_cmp++;
         if (act !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(HALF * 2 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      step(0, 0, 0, 16'h0000, 8'h00, "R1 idle after reset");
      step(1, 0, 0, 16'h1234, 8'h00, "R1 R6 boot flag set at reset");
      step(1, 0, 0, 16'h9000, 8'h00, "R1 page 0 at reset");
      step(1, 0, 0, 16'hC000, 8'h00, "R3 page 0 seg3");
      step(0, 1, 0, 16'h3000, 8'h00, "R7 sram under boot");
      step(0, 0, 1, 16'hF802, 8'h00, "R6 neighbour keeps boot");
      step(1, 0, 0, 16'h4000, 8'h00, "R6 boot still set");
      step(0, 0, 1, 16'hF801, 8'hA5, "R6 R7 boot clear write");
      step(1, 0, 0, 16'h0100, 8'h00, "R2 seg0");
      step(1, 0, 0, 16'h4000, 8'h00, "R2 R4 seg1");
      for (int p = 0; p < 4; p++) begin
         step(0, 0, 1, 16'hF800, 8'(p), "R5 page write");
         step(1, 0, 0, 16'h8000, 8'h00, "R3 R4 upper low segment");
         step(1, 0, 0, 16'hFFFF, 8'h00, "R3 R4 upper high segment");
         step(1, 0, 0, 16'h7FFF, 8'h00, "R2 common half page independent");
         step(0, 1, 0, 16'h0000, 8'h00, "R7 sram low edge");
         step(0, 0, 1, 16'h7FFF, 8'h00, "R7 sram high edge");
         step(0, 1, 0, 16'h8000, 8'h00, "R7 gap low edge");
         step(0, 1, 0, 16'hEFFF, 8'h00, "R7 gap high edge");
         step(0, 1, 0, 16'hF000, 8'h00, "R7 io edge");
      end
      step(0, 0, 1, 16'hF802, 8'h01, "R5 other address write");
      step(1, 0, 0, 16'hA000, 8'h00, "R5 page unchanged at 3");
      step(0, 0, 1, 16'h7800, 8'h01, "R5 sram write not a page write");
      step(1, 0, 0, 16'hA000, 8'h00, "R5 still page 3");
      step(0, 0, 1, 16'hF800, 8'hFD, "R5 low bits only");
      step(1, 0, 0, 16'hC123, 8'h00, "R5 page 1 from low bits");
      step(1, 1, 0, 16'h9000, 8'h00, "R8 fetch with rd");
      step(1, 0, 1, 16'h0000, 8'h00, "R8 fetch with wr");
      step(0, 1, 1, 16'h0010, 8'h00, "R8 rd with wr");
      step(0, 1, 1, 16'hF800, 8'h02, "R8 conflicting write ignored");
      step(1, 0, 0, 16'h8000, 8'h00, "R8 page kept after conflict");
      step(0, 1, 0, 16'hC000, 8'h00, "R8 read upper not flash");
      step(0, 0, 0, 16'h0000, 8'h00, "R8 idle");
      repeat (2) @(negedge clk);
      done = 1'b1;
      finish_run();
   end

endmodule